// File: doc/BRIEF.md
# Two-Level Interrupt Mask Arbiter

This block owns the two interrupt mask flags of a small 8-bit processor's condition codes. The high-level mask, `x_flag`, gates a single active-low non-maskable request. The low-level mask, `i_flag`, gates a vector of ordinary maskable requests. Each cycle the block decides whether an interrupt is taken and which one. When a request wins, it raises a one-cycle `take` pulse together with the winner's identity. It then waits for the sequencer to report that the condition codes have been saved to the stack, and raises the masks at that point.

Software can change both flags through a condition-code write port. The high-level mask is one-way: software may clear it but can never set it again, so after boot initialisation the request really is non-maskable. A return-from-interrupt restores both flags from values supplied by the sequencer.

The control is a two-state machine:
- `ST_IDLE` accepts requests.
- `ST_WAIT_STACK` blocks new requests until the stacked-flags strobe arrives.

Its transitions are:
- TAKE: `ST_IDLE` to `ST_WAIT_STACK`, when a request is pending.
- STACKED: `ST_WAIT_STACK` to `ST_IDLE`, on `ccr_stacked`.

Top module: `irq_mask_arbiter`

## Requirements
- R1: During and right after reset both `x_flag` and `i_flag` read 1, and no `take` is raised whatever the request inputs show.
- R2: A software write (`sw_wr`) copies `sw_i` into `i_flag` and may clear `x_flag` with `sw_x`=0. A write with `sw_x`=1 while `x_flag` is 0 leaves `x_flag` at 0.
- R3: The non-maskable request is pending when `nmi_n` is 0 and `x_flag` is 0, whatever the value of `i_flag`.
- R4: When the non-maskable request is pending, it is taken ahead of any maskable request (`take_nmi`=1, `take_idx`=0).
- R5: Maskable source k is pending when `mreq[k]`=1 and `i_flag`=0. The lowest pending index wins and is shown on `take_idx` with `take_nmi`=0.
- R6: `take` is combinational in `ST_IDLE`, lasts one cycle, and no further `take` appears until `ccr_stacked` has been seen in `ST_WAIT_STACK`.
- R7: `ccr_stacked` after a maskable take sets `i_flag` to 1 on the next edge and leaves `x_flag` unchanged.
- R8: `ccr_stacked` after a non-maskable take sets both `x_flag` and `i_flag` to 1 on the next edge.
- R9: `rti_restore` loads `x_flag`/`i_flag` from `rti_x`/`rti_i`, including setting `x_flag` back to 1. It wins over a software write in the same cycle.
- R10: An applied `ccr_stacked` strobe wins over both a software write and a restore in the same cycle.
- R11: `ccr_stacked` in `ST_IDLE` has no effect on the flags or the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_n | input | 1 | Active-low non-maskable request |
| mreq | input | NUM_SRC | Maskable requests, bit 0 highest priority |
| sw_wr | input | 1 | Software condition-code write strobe |
| sw_x | input | 1 | Written value for the high mask |
| sw_i | input | 1 | Written value for the low mask |
| ccr_stacked | input | 1 | Sequencer reports the flags were stacked |
| rti_restore | input | 1 | Return-from-interrupt restore strobe |
| rti_x | input | 1 | Restored high mask |
| rti_i | input | 1 | Restored low mask |
| x_flag | output | 1 | Current high mask |
| i_flag | output | 1 | Current low mask |
| take | output | 1 | Interrupt taken this cycle |
| take_nmi | output | 1 | The taken interrupt is the non-maskable one |
| take_idx | output | IDX_W | Index of the taken maskable source |

## Verification
A wrong flag value shows at the `x_flag`/`i_flag` ports one edge after the update that caused it. It also shows in the same cycle on `take` whenever a request is present. A state machine stuck in `ST_WAIT_STACK` suppresses every later `take`. One that fails to leave `ST_IDLE` gives a second `take` in the very next cycle. A mislatched interrupt kind shows as a wrong `x_flag` one edge after the stacked strobe.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
    typedef enum logic {
        ST_IDLE       = 1'b0,
        ST_WAIT_STACK = 1'b1
    } arb_state_t;
endpackage

// File: rtl/irq_mask_flags.sv
module irq_mask_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_apply,
    input  logic strobe_nmi,
    input  logic rti_restore,
    input  logic rti_x,
    input  logic rti_i,
    input  logic sw_wr,
    input  logic sw_x,
    input  logic sw_i,
    output logic x_q,
    output logic i_q
);
    // Update priority: stacked strobe, then restore, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= 1'b1;
            i_q <= 1'b1;
        end else if (strobe_apply) begin
            i_q <= 1'b1;
            x_q <= x_q | strobe_nmi;
        end else if (rti_restore) begin
            x_q <= rti_x;
            i_q <= rti_i;
        end else if (sw_wr) begin
            x_q <= x_q & sw_x;
            i_q <= sw_i;
        end
    end

    // R2
    sw_x_oneway_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !strobe_apply && !rti_restore && !x_q) |=> !x_q);
    // R7
    mask_keeps_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_apply && !strobe_nmi) |=> ($stable(x_q) && i_q));
    // R8
    nmi_sets_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_apply && strobe_nmi) |=> (x_q && i_q));
    // R9
    rti_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_restore && !strobe_apply) |=> (x_q == $past(rti_x) && i_q == $past(rti_i)));
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic               nmi_n,
    input  logic [NUM_SRC-1:0] mreq,
    input  logic               x_q,
    input  logic               i_q,
    output logic               nmi_pend,
    output logic               mask_pend,
    output logic [IDX_W-1:0]   win_idx
);
    logic [NUM_SRC-1:0] gated;

    always_comb begin
        nmi_pend  = !nmi_n && !x_q;
        gated     = i_q ? '0 : mreq;
        mask_pend = |gated;
        win_idx   = '0;
        // Scan downward so the lowest set bit is the last one written.
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (gated[k]) win_idx = IDX_W'(k);
        end
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_pend,
    input  logic             mask_pend,
    input  logic [IDX_W-1:0] win_idx,
    input  logic             ccr_stacked,
    output logic             take,
    output logic             take_nmi,
    output logic [IDX_W-1:0] take_idx,
    output logic             strobe_apply,
    output logic             strobe_nmi
);
    import irq_mask_pkg::*;

    arb_state_t state_q, state_d;
    logic       kind_nmi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            kind_nmi_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take) kind_nmi_q <= take_nmi;
        end
    end

    always_comb begin
        state_d      = state_q;
        take         = 1'b0;
        take_nmi     = 1'b0;
        take_idx     = '0;
        strobe_apply = 1'b0;
        strobe_nmi   = kind_nmi_q;
        unique case (state_q)
            ST_IDLE: begin
                if (nmi_pend || mask_pend) begin
                    take     = 1'b1;
                    take_nmi = nmi_pend;
                    take_idx = nmi_pend ? '0 : win_idx;
                    state_d  = ST_WAIT_STACK;
                end
            end
            ST_WAIT_STACK: begin
                if (ccr_stacked) begin
                    strobe_apply = 1'b1;
                    state_d      = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // R6
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
    // R11
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !take) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/irq_mask_arbiter.sv
module irq_mask_arbiter #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_n,
    input  logic [NUM_SRC-1:0] mreq,
    input  logic               sw_wr,
    input  logic               sw_x,
    input  logic               sw_i,
    input  logic               ccr_stacked,
    input  logic               rti_restore,
    input  logic               rti_x,
    input  logic               rti_i,
    output logic               x_flag,
    output logic               i_flag,
    output logic               take,
    output logic               take_nmi,
    output logic [IDX_W-1:0]   take_idx
);
    logic             nmi_pend, mask_pend, strobe_apply, strobe_nmi;
    logic [IDX_W-1:0] win_idx;

    irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .nmi_n(nmi_n), .mreq(mreq), .x_q(x_flag), .i_q(i_flag),
        .nmi_pend(nmi_pend), .mask_pend(mask_pend), .win_idx(win_idx)
    );

    irq_seq #(.NUM_SRC(NUM_SRC)) u_seq (
        .clk(clk), .rst_n(rst_n), .nmi_pend(nmi_pend), .mask_pend(mask_pend),
        .win_idx(win_idx), .ccr_stacked(ccr_stacked), .take(take),
        .take_nmi(take_nmi), .take_idx(take_idx),
        .strobe_apply(strobe_apply), .strobe_nmi(strobe_nmi)
    );

    irq_mask_flags u_flags (
        .clk(clk), .rst_n(rst_n), .strobe_apply(strobe_apply),
        .strobe_nmi(strobe_nmi), .rti_restore(rti_restore), .rti_x(rti_x),
        .rti_i(rti_i), .sw_wr(sw_wr), .sw_x(sw_x), .sw_i(sw_i),
        .x_q(x_flag), .i_q(i_flag)
    );

    // R4
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !nmi_n && !x_flag) |-> take_nmi);
    // R3
    gate_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (take_nmi ? !x_flag : (!i_flag && mreq[take_idx])));
endmodule

// File: tb/irq_mask_arbiter_bench.sv
module irq_mask_arbiter_bench;
    localparam int N = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic nmi_n = 1'b1;
    logic [N-1:0] mreq = '0;
    logic sw_wr = 0, sw_x = 0, sw_i = 0, ccr_stacked = 0;
    logic rti_restore = 0, rti_x = 0, rti_i = 0;
    logic x_flag, i_flag, take, take_nmi;
    logic [IW-1:0] take_idx;

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference model state
    bit m_x = 1, m_i = 1, m_wait = 0, m_kind = 0;

    always #4 clk = ~clk;

    irq_mask_arbiter #(.NUM_SRC(N)) u_irq_mask_arbiter (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .mreq(mreq), .sw_wr(sw_wr),
        .sw_x(sw_x), .sw_i(sw_i), .ccr_stacked(ccr_stacked),
        .rti_restore(rti_restore), .rti_x(rti_x), .rti_i(rti_i),
        .x_flag(x_flag), .i_flag(i_flag), .take(take), .take_nmi(take_nmi),
        .take_idx(take_idx)
    );

    function automatic int low_idx(input logic [N-1:0] v);
        for (int k = 0; k < N; k++) if (v[k]) return k;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at negedge, check shortly after, update model at posedge.
    task automatic step(input bit nn, input logic [N-1:0] mr, input bit w,
                        input bit wx, input bit wi, input bit st,
                        input bit rr, input bit rx, input bit ri);
        bit np, mp, e_take, e_nmi;
        int e_idx;
        @(negedge clk);
        nmi_n = nn; mreq = mr; sw_wr = w; sw_x = wx; sw_i = wi;
        ccr_stacked = st; rti_restore = rr; rti_x = rx; rti_i = ri;
        #1;
        np = !nn && !m_x;                       // R3
        mp = (mr != 0) && !m_i;                 // R5
        e_take = !m_wait && (np || mp);         // R6
        e_nmi  = e_take && np;                  // R4
        e_idx  = (e_take && !np) ? low_idx(mr) : 0;
        chk("R1 R2 R7 R8 R9 R10 x_flag", x_flag, m_x);
        chk("R1 R2 R7 R8 R9 R10 i_flag", i_flag, m_i);
        chk("R1 R3 R5 R6 take", take, e_take);
        chk("R3 R4 take_nmi", take_nmi, e_nmi);
        chk("R4 R5 take_idx", take_idx, e_idx);
        @(posedge clk);
        if (m_wait && st) begin                 // R7 R8 R10
            m_i = 1; m_x = m_x | m_kind;
        end else if (rr) begin                  // R9
            m_x = rx; m_i = ri;
        end else if (w) begin                   // R2
            m_x = m_x & wx; m_i = wi;
        end                                     // R11: idle strobe ignored
        if (m_wait && st) m_wait = 0;
        else if (e_take) begin m_wait = 1; m_kind = e_nmi; end
    endtask

    task automatic idle_in(input bit nn, input logic [N-1:0] mr);
        step(nn, mr, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #200000;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        fails++;
        checks++;
        done = 1;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        // R1: requests during reset phase do nothing
        @(negedge clk); nmi_n = 0; mreq = '1; #1;
        chk("R1 reset x", x_flag, 1); chk("R1 reset i", i_flag, 1);
        chk("R1 reset take", take, 0);
        @(negedge clk); rst_n = 1;
        idle_in(0, '1);                                 // R1 masked after reset
        step(1, 0, 1, 0, 1, 0, 0, 0, 0);                // R2 clear X, keep I
        step(1, 0, 1, 1, 1, 0, 0, 0, 0);                // R2 attempt set X ignored
        idle_in(1, 8'hFF);                              // R3 I still masks
        idle_in(0, 8'hFF);                              // R3 R4 NMI with I=1
        step(0, 0, 0, 0, 0, 1, 0, 0, 0);                // R8 strobe
        idle_in(0, 0);                                  // NMI now masked
        step(1, 0, 0, 0, 0, 1, 0, 0, 0);                // R11 idle strobe
        step(1, 0, 0, 0, 0, 0, 1, 0, 0);                // R9 restore X=0,I=0
        idle_in(1, 8'b0010_1000);                       // R5 idx 3
        step(1, 0, 1, 0, 0, 1, 1, 1, 0);                // R10 strobe wins
        step(1, 0, 1, 1, 0, 0, 1, 1, 1);                // R9 rti beats write
        step(1, 0, 1, 0, 0, 0, 0, 0, 0);                // clear both
        idle_in(1, 8'b1000_0000);                       // R5 idx 7
        idle_in(1, 8'b0000_0001);                       // R6 no take in wait
        step(1, 0, 0, 0, 0, 1, 0, 0, 0);                // R7 X stays 0
        for (int n = 0; n < 3000 && !done; n++) begin
            step(($urandom % 4) != 0,
                 (($urandom % 3) == 0) ? N'($urandom) & N'($urandom) : '0,
                 ($urandom % 8) == 0, $urandom % 2, $urandom % 2,
                 ($urandom % 3) == 0,
                 ($urandom % 16) == 0, ($urandom % 4) == 0, $urandom % 2);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge done) begin
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule